// File: doc/BRIEF.md
# Address-Window Cache Access Class Tagger

This block sits in front of a cache and attaches an access class to every memory request that passes through it. There are three classes: normal (plain recency replacement), streaming (evicted first) and persisting (evicted last). Software programs one address window, given as a start address and a length in bytes. It also programs a hit fraction and two classes: one for the hit share of the window and one for the rest of it. Addresses outside the window get the normal class.

The hit fraction is an 8-bit value in units of 1/256. The block folds the line-index bits of each address into an 8-bit hash. An in-window address gets the hit class when its hash is below the fraction, and the secondary class otherwise. The split is therefore fixed for a given address, so a buffer can be only partly protected from eviction. A per-access hint on the request that asks for low retention takes precedence over the window. The hint itself is forwarded unchanged.

Requests enter and leave on valid/ready handshakes. A single register stage sits between the two sides. Configuration is written through a plain select/data write port.

Top module: `acc_class_tagger`

## Requirements
- R1: While reset is asserted, and at the first edge after it, `out_valid` is 0. The configuration resets to base 0, length 0, fraction 0, and normal for both classes, so every request gets class code 0.
- R2: `in_ready` equals `!out_valid || out_ready`. A request accepted at a clock edge appears on the outputs right after that edge. While `out_valid && !out_ready`, the outputs hold their values.
- R3: An address is in the window when base ≤ addr < base + length. The sum is formed one bit wider than the address, so a window that ends at the top of the address space does not wrap. An address outside the window gets class 0 (normal).
- R4: Class codes are 0 normal, 1 streaming, 2 persisting. The hash is the XOR of the 8-bit groups of addr[31:7]: bit j of addr[31:7] feeds hash bit j mod 8. An in-window address with hash < fraction gets the hit class; any other in-window address gets the secondary class.
- R5: A fraction of 255 gives every in-window address the hit class. A fraction of 0 gives every in-window address the secondary class.
- R6: Hint codes are 0 none, 1 global-only, 2 streaming, 3 last-use and 4 volatile. Codes 2, 3 and 4 force class 1 whatever the window says. Codes 0 and 1 have no effect on the class. The hint is forwarded unchanged in every case.
- R7: A write with `cfg_we` high stores `cfg_wdata` into the field chosen by `cfg_sel`: 0 base, 1 length, 2 fraction (bits 7:0), 3 hit class (bits 1:0), 4 secondary class (bits 1:0). A request accepted at the same edge as the write is tagged with the old setting; later requests use the new one.
- R8: A write with `cfg_sel` = 5 clears the whole configuration to its reset values, after which every request without an overriding hint gets class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration field select |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_addr | input | 32 | Request byte address |
| in_hint | input | 3 | Per-access hint code |
| out_valid | output | 1 | Tagged request valid |
| out_ready | input | 1 | Downstream ready |
| out_addr | output | 32 | Forwarded address |
| out_hint | output | 3 | Forwarded hint code |
| out_class | output | 2 | Assigned access class |

## Verification
Each tagged result is due on the edge that accepts its request, so it can be observed on the outputs at the next falling edge. `in_ready` is combinational from the output state and `out_ready`, and it is checked in the same half cycle. A configuration write is applied one edge after it is presented, together with any request accepted at that same edge, so the bench's reference model tags that request before it applies the write. The model updates its state at every rising edge and is compared with the ports at every falling edge, including the cycles in which downstream stalls hold the output.

// File: rtl/acc_class_pkg.sv
package acc_class_pkg;

   typedef enum logic [1:0] {
      CLS_NORMAL  = 2'd0,
      CLS_STREAM  = 2'd1,
      CLS_PERSIST = 2'd2,
      CLS_RSVD    = 2'd3
   } acc_class_e;

   typedef enum logic [2:0] {
      HINT_NONE     = 3'd0,
      HINT_GLOBAL   = 3'd1,
      HINT_STREAM   = 3'd2,
      HINT_LASTUSE  = 3'd3,
      HINT_VOLATILE = 3'd4
   } acc_hint_e;

   localparam logic [2:0] SEL_BASE  = 3'd0;
   localparam logic [2:0] SEL_LEN   = 3'd1;
   localparam logic [2:0] SEL_FRAC  = 3'd2;
   localparam logic [2:0] SEL_HITC  = 3'd3;
   localparam logic [2:0] SEL_MISSC = 3'd4;
   localparam logic [2:0] SEL_CLEAR = 3'd5;

   function automatic logic hint_overrides(input logic [2:0] h);
      return (h == HINT_STREAM) || (h == HINT_LASTUSE) || (h == HINT_VOLATILE);
   endfunction

endpackage

// File: rtl/acc_window_cfg.sv
module acc_window_cfg
   import acc_class_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int RATIO_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [2:0]         sel,
   input  logic [ADDR_W-1:0]  wdata,
   output logic [ADDR_W-1:0]  base,
   output logic [ADDR_W-1:0]  len,
   output logic [RATIO_W-1:0] frac,
   output acc_class_e         hit_cls,
   output acc_class_e         miss_cls
);

   if (RATIO_W > ADDR_W) begin : g_bad_ratio
      $error("acc_window_cfg: RATIO_W must not exceed ADDR_W");
   end

   always_ff @(posedge clk) begin
      if (!rst_n || (we && sel == SEL_CLEAR)) begin
         base     <= '0;
         len      <= '0;
         frac     <= '0;
         hit_cls  <= CLS_NORMAL;
         miss_cls <= CLS_NORMAL;
      end else if (we) begin
         case (sel)
            SEL_BASE:  base     <= wdata;
            SEL_LEN:   len      <= wdata;
            SEL_FRAC:  frac     <= wdata[RATIO_W-1:0];
            SEL_HITC:  hit_cls  <= acc_class_e'(wdata[1:0]);
            SEL_MISSC: miss_cls <= acc_class_e'(wdata[1:0]);
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/acc_line_hash.sv
module acc_line_hash #(
   parameter int ADDR_W   = 32,
   parameter int LINE_LSB = 7,
   parameter int HASH_W   = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [HASH_W-1:0] hash
);

   localparam int IDX_W = ADDR_W - LINE_LSB;
   localparam int NGRP  = (IDX_W + HASH_W - 1) / HASH_W;
   localparam int PAD_W = NGRP * HASH_W;

   if (LINE_LSB < 0 || LINE_LSB >= ADDR_W) begin : g_bad_lsb
      $error("acc_line_hash: LINE_LSB out of range");
   end
   if (HASH_W < 1) begin : g_bad_hash
      $error("acc_line_hash: HASH_W must be positive");
   end

   logic [PAD_W-1:0]  padded;
   logic [HASH_W-1:0] fold [NGRP+1];

   if (PAD_W > IDX_W) begin : g_pad
      assign padded = {{(PAD_W-IDX_W){1'b0}}, addr[ADDR_W-1:LINE_LSB]};
   end else begin : g_nopad
      assign padded = addr[ADDR_W-1:LINE_LSB];
   end

   assign fold[0] = '0;
   for (genvar g = 0; g < NGRP; g++) begin : g_fold
      assign fold[g+1] = fold[g] ^ padded[g*HASH_W +: HASH_W];
   end

   assign hash = fold[NGRP];

endmodule

// File: rtl/acc_class_decide.sv
module acc_class_decide
   import acc_class_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int LINE_LSB = 7,
   parameter int RATIO_W  = 8
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [2:0]         hint,
   input  logic [ADDR_W-1:0]  base,
   input  logic [ADDR_W-1:0]  len,
   input  logic [RATIO_W-1:0] frac,
   input  acc_class_e         hit_cls,
   input  acc_class_e         miss_cls,
   output logic               in_win,
   output logic               forced,
   output acc_class_e         cls
);

   localparam int              WIDE_W  = ADDR_W + 1;
   localparam logic [RATIO_W-1:0] FULL_AT = {RATIO_W{1'b1}};

   logic [WIDE_W-1:0]  addr_w, lo_w, hi_w;
   logic [RATIO_W-1:0] hash;
   logic               take_hit;

   acc_line_hash #(
      .ADDR_W  (ADDR_W),
      .LINE_LSB(LINE_LSB),
      .HASH_W  (RATIO_W)
   ) hash_i (
      .addr(addr),
      .hash(hash)
   );

   assign addr_w = {1'b0, addr};
   assign lo_w   = {1'b0, base};
   assign hi_w   = {1'b0, base} + {1'b0, len};

   assign in_win   = (addr_w >= lo_w) && (addr_w < hi_w);
   assign take_hit = (frac >= FULL_AT) || (hash < frac);
   assign forced   = hint_overrides(hint);

   always_comb begin
      if (forced)        cls = CLS_STREAM;
      else if (!in_win)  cls = CLS_NORMAL;
      else if (take_hit) cls = hit_cls;
      else               cls = miss_cls;
   end

endmodule

// File: rtl/acc_class_tagger.sv
module acc_class_tagger
   import acc_class_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int LINE_LSB = 7,
   parameter int RATIO_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [2:0]        in_hint,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] out_addr,
   output logic [2:0]        out_hint,
   output logic [1:0]        out_class
);

   if (ADDR_W < 8) begin : g_bad_addr
      $error("acc_class_tagger: ADDR_W too small");
   end

   logic [ADDR_W-1:0]  c_base, c_len;
   logic [RATIO_W-1:0] c_frac;
   acc_class_e         c_hit, c_miss, d_cls;
   logic               d_in_win, d_forced, accept;

   acc_window_cfg #(.ADDR_W(ADDR_W), .RATIO_W(RATIO_W)) cfg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .sel     (cfg_sel),
      .wdata   (cfg_wdata),
      .base    (c_base),
      .len     (c_len),
      .frac    (c_frac),
      .hit_cls (c_hit),
      .miss_cls(c_miss)
   );

   acc_class_decide #(
      .ADDR_W  (ADDR_W),
      .LINE_LSB(LINE_LSB),
      .RATIO_W (RATIO_W)
   ) dec_i (
      .addr    (in_addr),
      .hint    (in_hint),
      .base    (c_base),
      .len     (c_len),
      .frac    (c_frac),
      .hit_cls (c_hit),
      .miss_cls(c_miss),
      .in_win  (d_in_win),
      .forced  (d_forced),
      .cls     (d_cls)
   );

   assign in_ready = !out_valid || out_ready;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_addr  <= '0;
         out_hint  <= '0;
         out_class <= CLS_NORMAL;
      end else if (accept) begin
         out_valid <= 1'b1;
         out_addr  <= in_addr;
         out_hint  <= in_hint;
         out_class <= d_cls;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // R2: a stalled output holds its contents
   assert_hold_on_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_hint)
                                  && $stable(out_class));

   // R2: an accepted request shows up on the next cycle
   assert_accept_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid && out_addr == $past(in_addr));

   // R3: outside the window and without a forcing hint the class is normal
   assert_outside_normal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !d_in_win && !d_forced |=> out_class == CLS_NORMAL);

   // R5: a saturated fraction always yields the hit class in the window
   assert_full_frac_R5: assert property (@(posedge clk) disable iff (!rst_n)
      accept && d_in_win && !d_forced && (&c_frac) |=> out_class == $past(c_hit));

   // R6: forcing hints yield streaming and travel unchanged
   assert_hint_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (in_hint == HINT_STREAM || in_hint == HINT_LASTUSE ||
                 in_hint == HINT_VOLATILE)
      |=> out_class == CLS_STREAM && out_hint == $past(in_hint));

   // R8: after a clear, unforced requests are normal
   assert_clear_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && cfg_sel == SEL_CLEAR |=> (in_valid && in_ready && !d_forced)
                                          |=> out_class == CLS_NORMAL);

endmodule

// File: tb/acc_class_tagger_tb_top.sv
module acc_class_tagger_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_addr = '0;
   logic [2:0]  in_hint = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_addr;
   logic [2:0]  out_hint;
   logic [1:0]  out_class;

   always #2.5 clk = ~clk;

   acc_class_tagger dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
      .in_addr(in_addr), .in_hint(in_hint), .out_valid(out_valid),
      .out_ready(out_ready), .out_addr(out_addr), .out_hint(out_hint),
      .out_class(out_class)
   );

   int n_vec = 0;
   int n_bad = 0;
   int cycles = 0;
   bit bp_mode = 1'b0;

   // reference model state
   bit          m_valid;
   logic [31:0] m_addr;
   logic [2:0]  m_hint;
   int          m_class;
   string       m_tag;
   logic [31:0] r_base, r_len;
   int          r_frac, r_hit, r_miss;
   bit          r_touched, r_cleared;
   bit          acc_flag;

   function automatic int line_hash(input logic [31:0] a);
      int h = 0;
      for (int j = 0; j < 25; j++)
         if (a[7+j]) h = h ^ (1 << (j % 8));
      return h;
   endfunction

   function automatic int model_class(input logic [31:0] a, input logic [2:0] h);
      longint lo, hi, aa;
      if (h >= 3'd2 && h <= 3'd4) return 1;
      lo = longint'(r_base);
      hi = lo + longint'(r_len);
      aa = longint'(a);
      if (aa < lo || aa >= hi) return 0;
      if (r_frac == 255 || line_hash(a) < r_frac) return r_hit;
      return r_miss;
   endfunction

   function automatic string model_tag(input logic [31:0] a, input logic [2:0] h);
      longint lo, hi, aa;
      lo = longint'(r_base);
      hi = lo + longint'(r_len);
      aa = longint'(a);
      if (cfg_we) return "R7";
      if (h >= 3'd2 && h <= 3'd4) return "R6";
      if (!r_touched) return "R1";
      if (r_cleared) return "R8";
      if (aa < lo || aa >= hi) return "R3";
      if (r_frac == 255 || r_frac == 0) return "R5";
      return "R4";
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_valid = 0; r_base = 0; r_len = 0; r_frac = 0; r_hit = 0; r_miss = 0;
         r_touched = 0; r_cleared = 0; acc_flag = 0;
      end else begin
         acc_flag = in_valid && (!m_valid || out_ready);
         if (acc_flag) begin
            m_valid = 1; m_addr = in_addr; m_hint = in_hint;
            m_class = model_class(in_addr, in_hint);
            m_tag = model_tag(in_addr, in_hint);
         end else if (out_ready) m_valid = 0;
         if (cfg_we) begin
            r_touched = 1;
            case (cfg_sel)
               3'd0: begin r_base = cfg_wdata; r_cleared = 0; end
               3'd1: begin r_len = cfg_wdata; r_cleared = 0; end
               3'd2: r_frac = int'(cfg_wdata[7:0]);
               3'd3: r_hit = int'(cfg_wdata[1:0]);
               3'd4: r_miss = int'(cfg_wdata[1:0]);
               3'd5: begin
                  r_base = 0; r_len = 0; r_frac = 0; r_hit = 0; r_miss = 0;
                  r_cleared = 1;
               end
               default: ;
            endcase
         end
      end
   end

   task automatic compare();
      n_vec++;
      if (in_ready !== (!m_valid || out_ready)) begin
         n_bad++;
         $display("FAIL R2: in_ready got %0b expected %0b", in_ready, !m_valid || out_ready);
      end
      if (out_valid !== m_valid) begin
         n_bad++;
         $display("FAIL R2: out_valid got %0b expected %0b", out_valid, m_valid);
      end else if (m_valid) begin
         if (out_addr !== m_addr || out_hint !== m_hint) begin
            n_bad++;
            $display("FAIL R2: addr/hint got %h/%0d expected %h/%0d",
                     out_addr, out_hint, m_addr, m_hint);
         end
         if (int'(out_class) != m_class) begin
            n_bad++;
            $display("FAIL %s: class for %h got %0d expected %0d",
                     m_tag, m_addr, out_class, m_class);
         end
      end
   endtask

   task automatic tick();
      @(negedge clk);
      compare();
      out_ready = bp_mode ? 1'($urandom % 2) : 1'b1;
   endtask

   task automatic send(input logic [31:0] a, input logic [2:0] h);
      in_valid = 1'b1; in_addr = a; in_hint = h;
      do tick(); while (!acc_flag);
      in_valid = 1'b0;
   endtask

   task automatic wr(input logic [2:0] s, input logic [31:0] d);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
      tick();
      cfg_we = 1'b0;
   endtask

   always @(posedge clk) begin
      if (cycles > 100000) begin
         n_bad++;
         $display("FAIL watchdog: cycles got %0d expected below 100000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      n_vec++;
      if (out_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: out_valid in reset got %0b expected 0", out_valid);
      end
      rst_n = 1'b1;
      tick();
      send(32'h0000_1234, 3'd0);   // R1: default configuration gives normal
      tick();

      // R4: fractional split with persisting hits, streaming remainder
      wr(3'd0, 32'h0001_0000);
      wr(3'd1, 32'h0002_0000);
      wr(3'd2, 32'd128);
      wr(3'd3, 32'd2);
      wr(3'd4, 32'd1);
      for (int i = 0; i < 40; i++) send(32'h0001_0000 + 32'(i) * 32'h80, 3'd0);
      // R3: edges of the window
      send(32'h0000_FFFF, 3'd0);
      send(32'h0001_0000, 3'd0);
      send(32'h0002_FFFF, 3'd0);
      send(32'h0003_0000, 3'd0);
      // R6: every hint code inside and outside
      for (int h = 0; h < 5; h++) begin
         send(32'h0001_8000, 3'(h));
         send(32'h8000_0000, 3'(h));
      end
      tick();

      // R3: window touching the top of the address space
      wr(3'd0, 32'hFFFF_F000);
      wr(3'd1, 32'h0000_1000);
      send(32'hFFFF_FFFF, 3'd0);
      send(32'hFFFF_EFFF, 3'd0);
      send(32'h0000_0000, 3'd0);

      // R5: saturated and zero fraction
      wr(3'd0, 32'h0004_0000);
      wr(3'd1, 32'h0000_4000);
      wr(3'd2, 32'd255);
      for (int i = 0; i < 16; i++) send(32'h0004_0000 + 32'(i) * 32'h400, 3'd0);
      wr(3'd2, 32'd0);
      for (int i = 0; i < 16; i++) send(32'h0004_0000 + 32'(i) * 32'h400, 3'd1);

      // R7: write presented in the same cycle as a request
      wr(3'd2, 32'd255);
      cfg_we = 1'b1; cfg_sel = 3'd3; cfg_wdata = 32'd1;
      send(32'h0004_0080, 3'd0);
      cfg_we = 1'b0;
      send(32'h0004_0080, 3'd0);

      // R2: random traffic under backpressure with a mid-range fraction
      wr(3'd2, 32'd77);
      wr(3'd3, 32'd2);
      bp_mode = 1'b1;
      for (int i = 0; i < 300; i++) begin
         send(32'h0003_C000 + ($urandom % 32'h0000_C000), 3'($urandom % 5));
         if ($urandom % 4 == 0) tick();
      end
      bp_mode = 1'b0;
      tick();
      tick();

      // R8: clearing returns every address to normal
      wr(3'd5, 32'd0);
      for (int i = 0; i < 8; i++) send(32'h0004_0000 + 32'(i) * 32'h800, 3'd0);
      tick();
      tick();

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule